// File: doc/BRIEF.md
# 100BASE-X PCS Transmit Encoder

This block sits between a media access controller's 4-bit transmit port and a fiber optic transmitter. Once per symbol period, marked by a divide-by-5 enable from the 125 MHz bit clock, it samples a nibble along with the transmit enable and transmit error strobes. It turns each nibble into a 5-bit code group and shifts the group out at the bit rate. The serial stream is converted to NRZI before it leaves the block. Each packet is framed with a two-symbol start delimiter and a two-symbol end delimiter. Between packets the block sends continuous idle. While the error strobe is raised during a packet, it sends the halt code group.

The block also produces a 25 MHz transmit clock that is phase-aligned to the bit clock, for the MAC to launch data on. It raises an activity flag that the carrier sense logic uses. The start delimiter reaches the line a fixed number of bit times after the transmit enable is sampled. That number is set by a symbol pipeline depth parameter.

Top module: `fx_pcs_tx`

## Requirements
- R1: Inputs `mii_txd`, `mii_txen` and `mii_txer` are sampled only at a clock edge where `sym_en` is high, and are ignored at every other edge. `tx_clk_o` goes high at each such edge, stays high for two bit-clock cycles and is then low for three. Before the first `sym_en` edge after reset, `tx_clk_o` is low.
- R2: Each data nibble is mapped to a 5-bit code group using this table:
  0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
  Code groups are sent leftmost (most significant) bit first.
- R3: The line uses NRZI coding. `serial_o` toggles for a code bit of 1 and holds its level for a code bit of 0.
- R4: While no packet is in progress, the idle group 11111 is sent, so `serial_o` toggles on every bit-clock cycle.
- R5: Sampling `mii_txen` high in idle emits J (11000) in place of that nibble. The next sampled nibble is always replaced by K (10001), even if `mii_txen` has dropped by then.
- R6: During data, a sampled nibble that has `mii_txer` high is sent as H (00100), for as many symbols as the strobe stays high. While `mii_txen` is low, `mii_txer` has no effect.
- R7: The first sampled low `mii_txen` after data emits T (01101), and the next symbol emits R (00111). `mii_txen` is ignored at the R symbol. Idle or a new J follows.
- R8: The first bit of J appears on `serial_o` 1+5·(PIPE_STAGES+1) bit-clock edges after the edge that sampled `mii_txen` high. With the default setting this is 11 edges.
- R9: `tx_active_o` is high exactly while a J, K, data, H, T or R group is in the serializer. It rises at the edge that loads J, which is one edge before J's first line bit, and it falls at the edge that loads the idle group after R.
- R10: During reset, `serial_o`, `tx_active_o` and `tx_clk_o` are all 0. After reset the pipeline holds idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Divide-by-5 enable, high for one cycle per symbol |
| mii_txd | input | 4 | Transmit nibble |
| mii_txen | input | 1 | Transmit enable |
| mii_txer | input | 1 | Transmit error strobe |
| tx_clk_o | output | 1 | 25 MHz transmit clock, aligned to symbol boundaries |
| serial_o | output | 1 | NRZI line bit |
| tx_active_o | output | 1 | Frame is in the serializer |

## Verification
The hardest case to reach is `mii_txen` rising again while the end delimiter's R symbol is being chosen. The R slot must swallow that nibble, and the J must follow one symbol later. A directed sequence drops the enable for exactly one symbol right after data, then raises it again. One-nibble packets cover the K-to-T path. Back-to-back halt symbols and error strobes during idle cover R6. Random packets of mixed length and gap follow. Garbage is driven on the inputs between enable edges.

// File: rtl/fx_pcs_tx_pkg.sv
package fx_pcs_tx_pkg;

    localparam int NIB_W  = 4;
    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_IDLE = 5'b11111;
    localparam code_t C_J    = 5'b11000;
    localparam code_t C_K    = 5'b10001;
    localparam code_t C_T    = 5'b01101;
    localparam code_t C_R    = 5'b00111;
    localparam code_t C_H    = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SSD2,
        ST_DATA,
        ST_ESD2
    } frm_state_e;

    typedef struct packed {
        code_t code;
        logic  act;
    } sym_t;

    localparam sym_t SYM_IDLE = '{code: C_IDLE, act: 1'b0};

    function automatic code_t nib_to_code(input logic [NIB_W-1:0] n);
        code_t c;
        unique case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            4'hF: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
    import fx_pcs_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             txen,
    input  logic             txer,
    output sym_t             sym_o
);

    typedef struct packed {
        frm_state_e state;
        sym_t       sym;
    } frm_regs_t;

    frm_regs_t frm_d, frm_q;

    always_comb begin
        frm_d = frm_q;
        if (sym_en) begin
            unique case (frm_q.state)
                ST_IDLE: begin
                    if (txen) begin
                        frm_d.sym   = '{code: C_J, act: 1'b1};
                        frm_d.state = ST_SSD2;
                    end else begin
                        frm_d.sym   = SYM_IDLE;
                    end
                end
                ST_SSD2: begin
                    frm_d.sym   = '{code: C_K, act: 1'b1};
                    frm_d.state = ST_DATA;
                end
                ST_DATA: begin
                    if (txen) begin
                        frm_d.sym = '{code: (txer ? C_H : nib_to_code(txd)), act: 1'b1};
                    end else begin
                        frm_d.sym   = '{code: C_T, act: 1'b1};
                        frm_d.state = ST_ESD2;
                    end
                end
                ST_ESD2: begin
                    frm_d.sym   = '{code: C_R, act: 1'b1};
                    frm_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '{state: ST_IDLE, sym: SYM_IDLE};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign sym_o = frm_q.sym;

    // R5: enable seen in idle opens the frame with J
    a_r5_ssd_first: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_q.state == ST_IDLE && txen) |=> (sym_o.code == C_J && sym_o.act));

    // R6: error strobe inside data yields halt
    a_r6_halt_sub: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_q.state == ST_DATA && txen && txer) |=> (sym_o.code == C_H));

    // R6: error strobe without enable in idle changes nothing
    a_r6_txer_ignored: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_q.state == ST_IDLE && !txen) |=> (sym_o.code == C_IDLE && !sym_o.act));

    // R7: enable falling in data produces T
    a_r7_esd_first: assert property (@(posedge clk) disable iff (rst)
        (sym_en && frm_q.state == ST_DATA && !txen) |=> (sym_o.code == C_T));

endmodule

// File: rtl/fx_tx_symdelay.sv
module fx_tx_symdelay
    import fx_pcs_tx_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_en,
    input  sym_t sym_i,
    output sym_t sym_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sym_o = sym_i;
        end else begin : g_pipe
            sym_t stage_d [STAGES];
            sym_t stage_q [STAGES];

            always_comb begin
                for (int i = 0; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i];
                end
                if (sym_en) begin
                    stage_d[0] = sym_i;
                    for (int i = 1; i < STAGES; i++) begin
                        stage_d[i] = stage_q[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stage_q[i] <= SYM_IDLE;
                    end
                end else begin
                    for (int i = 0; i < STAGES; i++) begin
                        stage_q[i] <= stage_d[i];
                    end
                end
            end

            assign sym_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fx_tx_serializer.sv
module fx_tx_serializer
    import fx_pcs_tx_pkg::*;
#(
    parameter int CLK_HI = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_en,
    input  sym_t sym_i,
    output logic serial_o,
    output logic active_o,
    output logic txclk_o
);

    localparam int PH_W   = $clog2(CODE_W);
    localparam int PH_MAX = CODE_W - 1;

    typedef struct packed {
        code_t           shreg;
        logic            act;
        logic            line;
        logic [PH_W-1:0] phase;
    } ser_regs_t;

    ser_regs_t ser_d, ser_q;

    always_comb begin
        ser_d      = ser_q;
        ser_d.line = ser_q.line ^ ser_q.shreg[CODE_W-1];
        if (sym_en) begin
            ser_d.shreg = sym_i.code;
            ser_d.act   = sym_i.act;
            ser_d.phase = '0;
        end else begin
            ser_d.shreg = {ser_q.shreg[CODE_W-2:0], 1'b1};
            if (ser_q.phase != PH_W'(PH_MAX)) begin
                ser_d.phase = ser_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= '{shreg: C_IDLE, act: 1'b0, line: 1'b0, phase: PH_W'(PH_MAX)};
        end else begin
            ser_q <= ser_d;
        end
    end

    assign serial_o = ser_q.line;
    assign active_o = ser_q.act;
    assign txclk_o  = (ser_q.phase < PH_W'(CLK_HI));

    // R1: transmit clock is high right after a symbol edge
    a_r1_txclk_rise: assert property (@(posedge clk) disable iff (rst)
        sym_en |=> txclk_o);

    // R9: activity flag only changes at a symbol load
    a_r9_active_steady: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> $stable(active_o));

endmodule

// File: rtl/fx_pcs_tx.sv
module fx_pcs_tx
    import fx_pcs_tx_pkg::*;
#(
    parameter int PIPE_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_en,
    input  logic [NIB_W-1:0] mii_txd,
    input  logic             mii_txen,
    input  logic             mii_txer,
    output logic             tx_clk_o,
    output logic             serial_o,
    output logic             tx_active_o
);

    sym_t frm_sym;
    sym_t dly_sym;

    fx_tx_framer u_framer (
        .clk    (clk),
        .rst    (rst),
        .sym_en (sym_en),
        .txd    (mii_txd),
        .txen   (mii_txen),
        .txer   (mii_txer),
        .sym_o  (frm_sym)
    );

    fx_tx_symdelay #(.STAGES(PIPE_STAGES)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .sym_en (sym_en),
        .sym_i  (frm_sym),
        .sym_o  (dly_sym)
    );

    fx_tx_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .sym_en   (sym_en),
        .sym_i    (dly_sym),
        .serial_o (serial_o),
        .active_o (tx_active_o),
        .txclk_o  (tx_clk_o)
    );

    // R4: outside a frame the line toggles every bit
    a_r4_idle_toggle: assert property (@(posedge clk) disable iff (rst)
        !tx_active_o |=> (serial_o != $past(serial_o)));

endmodule

// File: tb/fx_pcs_tx_bench.sv
module fx_pcs_tx_bench;

    localparam int PIPE = 1;
    localparam int LAT  = 1 + 5 * (PIPE + 1);
    localparam int NSYM = 1040;
    localparam int NCYC = 5 * NSYM + 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       sym_en;
    logic [3:0] mii_txd;
    logic       mii_txen;
    logic       mii_txer;
    logic       tx_clk_o;
    logic       serial_o;
    logic       tx_active_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic  exp_bit [64];
    logic  exp_act [64];
    string exp_tag [64];
    logic  line_exp;
    int    ms;
    int    pkt_left;
    int    gap_left;

    always #10 clk = ~clk;

    fx_pcs_tx #(.PIPE_STAGES(PIPE)) u_fx_pcs_tx (
        .clk         (clk),
        .rst         (rst),
        .sym_en      (sym_en),
        .mii_txd     (mii_txd),
        .mii_txen    (mii_txen),
        .mii_txer    (mii_txer),
        .tx_clk_o    (tx_clk_o),
        .serial_o    (serial_o),
        .tx_active_o (tx_active_o)
    );

    function automatic logic [4:0] ref_code(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(input logic got, input logic expv, input string tag, input string what);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, expv, $time);
        end
    endtask

    // Reference framing model, from the requirements
    task automatic model_symbol(input int s, input logic en, input logic er, input logic [3:0] d);
        logic [4:0] c;
        logic       a;
        string      tag;
        a = 1'b1;
        case (ms)
            0: if (en) begin c = 5'b11000; tag = "R5"; ms = 1; end
               else begin c = 5'b11111; a = 1'b0; tag = "R3/R4/R6"; end
            1: begin c = 5'b10001; tag = "R5"; ms = 2; end
            2: if (en) begin
                   if (er) begin c = 5'b00100; tag = "R6"; end
                   else begin c = ref_code(d); tag = "R2/R3"; end
               end else begin c = 5'b01101; tag = "R7"; ms = 3; end
            default: begin c = 5'b00111; tag = "R7"; ms = 0; end
        endcase
        for (int i = 0; i < 5; i++) begin
            exp_bit[(s + LAT + i) % 64] = c[4-i];
            exp_tag[(s + LAT + i) % 64] = (i == 0 && c == 5'b11000) ? "R8" : tag;
        end
        for (int j = 0; j < 5; j++) begin
            exp_act[(s + LAT - 1 + j) % 64] = a;
        end
    endtask

    task automatic get_stim(input int k, output logic en, output logic er, output logic [3:0] d);
        d  = 4'($urandom);
        er = 1'b0;
        en = 1'b0;
        if (k < 40) begin
            if (k < 4) er = 1'b1;                          // R6: strobe alone in idle
            else if (k == 4) en = 1'b1;                    // R5: single-nibble packet
            else if (k >= 9 && k <= 14) begin
                en = 1'b1;
                er = (k == 12 || k == 13);                 // R6: consecutive halts
            end else if (k >= 20 && k <= 23) en = 1'b1;
            else if (k >= 25 && k <= 30) en = 1'b1;        // R7: enable back during R
            else if (k >= 32) er = ($urandom_range(0, 1) == 1);
        end else begin
            if (pkt_left > 0) begin
                en = 1'b1;
                er = ($urandom_range(0, 9) == 0);
                pkt_left--;
                if (pkt_left == 0) gap_left = $urandom_range(0, 6);
            end else if (gap_left > 0) begin
                er = ($urandom_range(0, 3) == 0);
                gap_left--;
            end else begin
                en = 1'b1;
                pkt_left = $urandom_range(0, 11);
                if (pkt_left == 0) gap_left = $urandom_range(0, 6);
            end
        end
    endtask

    initial begin
        int k;
        logic en, er;
        logic [3:0] d;
        void'($urandom(32'd24680));
        for (int i = 0; i < 64; i++) begin
            exp_bit[i] = 1'b1;
            exp_act[i] = 1'b0;
            exp_tag[i] = "R3/R4";
        end
        ms = 0; pkt_left = 0; gap_left = 0; k = 0;
        line_exp = 1'b0;
        rst = 1'b1; sym_en = 1'b0; mii_txd = '0; mii_txen = 1'b0; mii_txer = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(serial_o, 1'b0, "R10", "serial in reset");
            check(tx_active_o, 1'b0, "R10", "active in reset");
            check(tx_clk_o, 1'b0, "R10", "txclk in reset");
        end
        rst = 1'b0;
        for (int m = 1; m <= NCYC; m++) begin
            @(negedge clk);
            line_exp = line_exp ^ exp_bit[m % 64];
            check(serial_o, line_exp, exp_tag[m % 64], "line level");
            check(tx_active_o, exp_act[m % 64], "R9", "active flag");
            check(tx_clk_o, (m >= 5) && ((m % 5) < 2), "R1", "transmit clock");
            exp_bit[m % 64] = 1'b1;
            exp_act[m % 64] = 1'b0;
            exp_tag[m % 64] = "R3/R4";
            sym_en = (((m + 1) % 5) == 0);
            if (sym_en) begin
                get_stim(k, en, er, d);
                k++;
                mii_txen = en; mii_txer = er; mii_txd = d;
                model_symbol(m + 1, en, er, d);
            end else begin
                // R1: values between symbol edges must be ignored
                mii_txen = 1'($urandom); mii_txer = 1'($urandom); mii_txd = 4'($urandom);
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule